// File: doc/BRIEF.md
# Rate-Change Phase Sequencer

This block sets the sample-phase timing at the front of a 2:1 rate-changing filter datapath. One master clock drives it, and that clock always runs at the higher of the two sample rates. Two static mode inputs select the operation. In up-conversion (interpolation), the block registers an input word on every second rising edge and passes a zero sample on each edge in between. In down-conversion (decimation), it registers input on every edge and enables the downstream output register on every second edge only. When both mode inputs are low, or both are high, the block passes data straight through and asserts both enables on every edge.

An alignment input sets the phase. When it is seen high on one edge and low on the next, the second edge becomes a capture edge. After that, the phase holds whether the alignment input stays low or toggles at half the clock rate. Before any alignment event, the phase runs freely from its reset state. The input word may be unsigned. In that case its MSB is inverted so that the datapath always receives two's complement.

Top module: `rate_phase_seq`

## Requirements
- R1: While rst_ni is low, sample_o is 0. The first rising edge after reset is a capture edge (capture_en_o high in up-conversion mode).
- R2: In up-conversion mode (interp_i=1, decim_i=0), capture_en_o is high on alternate edges. On a capture edge, sample_o takes the converted input word after that edge. On any other edge, sample_o becomes 0.
- R3: If align_i was high at the previous edge and is low at the current edge, the current edge is a capture edge. The edge after it is a non-capture edge.
- R4: After alignment, driving align_i as a square wave at half the clock rate keeps capture on the edges where align_i is low.
- R5: After alignment, holding align_i low keeps capture and non-capture edges strictly alternating.
- R6: In down-conversion mode (interp_i=0, decim_i=1), capture_en_o is always high and sample_o follows the input on every edge. outreg_en_o is high only on non-capture phase edges, which means it is high on alternate edges and low on the edge that an alignment pattern marks.
- R7: When interp_i and decim_i are equal, capture_en_o and outreg_en_o are both high on every edge, align_i has no effect on them, and sample_o follows the input on every edge.
- R8: With fmt_unsigned_i=1, the registered word is the input with bit DATA_W-1 inverted. With fmt_unsigned_i=0, it is the input unchanged. A zero-inserted sample is 0 in either format.
- R9: Before any alignment event, the phase alternates freely from the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, at the higher sample rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| interp_i | input | 1 | Static up-conversion mode select |
| decim_i | input | 1 | Static down-conversion mode select |
| align_i | input | 1 | Phase alignment input |
| fmt_unsigned_i | input | 1 | Input word is unsigned when high |
| data_i | input | DATA_W | Input sample word |
| sample_o | output | DATA_W | Registered two's complement sample to the datapath |
| capture_en_o | output | 1 | High on edges where the input word is taken |
| outreg_en_o | output | 1 | Enable for the downstream output register |

## Verification
The bench builds the block with the default 12-bit word width. At that width the MSB inversion at bit 11 and the full-scale codes 0x800 and 0x7FF fall inside the vector table. One continuous vector sequence walks through free-running phase after reset, realignment during an ongoing alternation, square-wave and held-low alignment input, down-conversion with a realignment, and both pass-through encodings. Directed tests then reset the block in mid-run and check the free phase that follows.

// File: rtl/rate_phase_pkg.sv
package rate_phase_pkg;
  typedef enum logic [1:0] {
    MODE_PASS   = 2'd0,
    MODE_INTERP = 2'd1,
    MODE_DECIM  = 2'd2
  } rate_mode_e;

  function automatic rate_mode_e decode_mode(input logic interp, input logic decim);
    if (interp && !decim)      return MODE_INTERP;
    else if (decim && !interp) return MODE_DECIM;
    else                       return MODE_PASS;
  endfunction
endpackage

// File: rtl/phase_gen.sv
module phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic align_i,
  output logic accept_o
);
  logic align_q;
  logic phase_q;  // 1: next edge is a capture edge

  // high-then-low on align forces the capture phase
  assign accept_o = (align_q && !align_i) ? 1'b1 : phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      align_q <= 1'b0;
      phase_q <= 1'b1;
    end else begin
      align_q <= align_i;
      phase_q <= ~accept_o;
    end
  end
endmodule

// File: rtl/sample_reg.sv
module sample_reg #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              zero_i,
  input  logic              fmt_unsigned_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] sample_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] conv_d;

  always_comb begin
    conv_d      = data_i;
    conv_d[MSB] = data_i[MSB] ^ fmt_unsigned_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sample_o <= '0;
    else if (zero_i) sample_o <= '0;
    else             sample_o <= conv_d;
  end
endmodule

// File: rtl/rate_phase_seq.sv
module rate_phase_seq
  import rate_phase_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              interp_i,
  input  logic              decim_i,
  input  logic              align_i,
  input  logic              fmt_unsigned_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] sample_o,
  output logic              capture_en_o,
  output logic              outreg_en_o
);
  rate_mode_e mode;
  logic       accept;
  logic       zero_ins;

  assign mode = decode_mode(interp_i, decim_i);

  phase_gen u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .align_i  (align_i),
    .accept_o (accept)
  );

  always_comb begin
    capture_en_o = 1'b1;
    outreg_en_o  = 1'b1;
    zero_ins     = 1'b0;
    unique case (mode)
      MODE_INTERP: begin
        capture_en_o = accept;
        zero_ins     = ~accept;
      end
      MODE_DECIM:  outreg_en_o = ~accept;
      default: ;
    endcase
  end

  sample_reg #(.DATA_W(DATA_W)) u_sample (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .zero_i         (zero_ins),
    .fmt_unsigned_i (fmt_unsigned_i),
    .data_i         (data_i),
    .sample_o       (sample_o)
  );
endmodule

// File: rtl/rate_phase_seq_chk.sv
module rate_phase_seq_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              interp_i,
  input logic              decim_i,
  input logic              align_i,
  input logic              fmt_unsigned_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] sample_o,
  input logic              capture_en_o,
  input logic              outreg_en_o
);
  localparam int MSB = DATA_W - 1;

  logic up_m, down_m, pass_m, align_d, past_ok;
  assign up_m   = interp_i && !decim_i;
  assign down_m = decim_i && !interp_i;
  assign pass_m = interp_i == decim_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      align_d <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      align_d <= align_i;
      past_ok <= 1'b1;
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> sample_o == '0);

  // R2
  zero_insert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_m && !capture_en_o) |=> sample_o == '0);

  // R3
  align_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && up_m && align_d && !align_i) |-> capture_en_o);

  // R5
  alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_m && capture_en_o) |=> (!up_m || !capture_en_o || (align_d && !align_i)));

  // R6
  decim_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    down_m |-> capture_en_o);

  // R6
  decim_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (down_m && outreg_en_o) |=> (!down_m || !outreg_en_o));

  // R7
  pass_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_m |-> (capture_en_o && outreg_en_o));

  // R8
  msb_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_en_o && fmt_unsigned_i) |=> sample_o[MSB] == !$past(data_i[MSB]));
endmodule

bind rate_phase_seq rate_phase_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/rate_phase_seq_bench.sv
module rate_phase_seq_bench;
  localparam int DATA_W = 12;
  localparam int NV = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic interp, decim, align, uns;
  logic [DATA_W-1:0] data;
  logic [DATA_W-1:0] sample;
  logic cap_en, oreg_en;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rate_phase_seq #(.DATA_W(DATA_W)) u_rate_phase_seq (
    .clk_i(clk), .rst_ni(rst_n), .interp_i(interp), .decim_i(decim),
    .align_i(align), .fmt_unsigned_i(uns), .data_i(data),
    .sample_o(sample), .capture_en_o(cap_en), .outreg_en_o(oreg_en)
  );

  // {interp, decim, align, uns, data[11:0], cap, oen, expected sample[11:0]}
  localparam logic [29:0] VEC [NV] = '{
    {4'b1000, 12'h111, 2'b11, 12'h111},  // R1 R9 first edge captures
    {4'b1000, 12'h222, 2'b01, 12'h000},  // R2 R9
    {4'b1010, 12'h333, 2'b11, 12'h333},  // R2
    {4'b1000, 12'h444, 2'b11, 12'h444},  // R3 realign
    {4'b1010, 12'h555, 2'b01, 12'h000},  // R4
    {4'b1000, 12'h666, 2'b11, 12'h666},  // R4
    {4'b1010, 12'h777, 2'b01, 12'h000},  // R4
    {4'b1000, 12'h888, 2'b11, 12'h888},  // R4
    {4'b1000, 12'h999, 2'b01, 12'h000},  // R5
    {4'b1000, 12'hAAA, 2'b11, 12'hAAA},  // R5
    {4'b0100, 12'hBBB, 2'b11, 12'hBBB},  // R6
    {4'b0100, 12'hCCC, 2'b10, 12'hCCC},  // R6
    {4'b0110, 12'h123, 2'b11, 12'h123},  // R6
    {4'b0100, 12'h456, 2'b10, 12'h456},  // R6 realign
    {4'b0110, 12'h789, 2'b11, 12'h789},  // R6
    {4'b0000, 12'hABC, 2'b11, 12'hABC},  // R7
    {4'b0010, 12'hDEF, 2'b11, 12'hDEF},  // R7
    {4'b1100, 12'h0F0, 2'b11, 12'h0F0},  // R7
    {4'b1001, 12'h800, 2'b01, 12'h000},  // R8 zero stays 0
    {4'b1001, 12'h800, 2'b11, 12'h000},  // R8
    {4'b1001, 12'h7FF, 2'b01, 12'h000},  // R8
    {4'b1001, 12'h7FF, 2'b11, 12'hFFF},  // R8
    {4'b0101, 12'h123, 2'b11, 12'h923}   // R8 R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    interp = 1'b1; decim = 1'b0; align = 1'b0; uns = 1'b0; data = '0;
    #5;
    check("R1", 32'(sample), 32'h0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {interp, decim, align, uns, data} = VEC[i][29:14];
      #1;
      check($sformatf("R2/R6/R7 en vec %0d", i), 32'({cap_en, oreg_en}), 32'(VEC[i][13:12]));
      @(negedge clk);
      check($sformatf("R2/R8 sample vec %0d", i), 32'(sample), 32'(VEC[i][11:0]));
    end
    // R1 reset mid-run, then R9 free phase from reset
    interp = 1'b1; decim = 1'b0; align = 1'b0; uns = 1'b0; data = 12'h5A5;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", 32'(sample), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 capture first", 32'(cap_en), 32'h1);
    @(negedge clk);
    check("R1 sample", 32'(sample), 32'h5A5);
    #1;
    check("R9 skip", 32'(cap_en), 32'h0);
    @(negedge clk);
    check("R9 zero", 32'(sample), 32'h0);
    #1;
    check("R9 capture", 32'(cap_en), 32'h1);
    // R7 align pattern leaves pass-through enables high
    decim = 1'b1; align = 1'b1;
    @(negedge clk);
    align = 1'b0;
    #1;
    check("R7 align ignored", 32'({cap_en, oreg_en}), 32'h3);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule